// File: doc/BRIEF.md
# Dual-Sided Messaging Unit

This block links two processors, side A and side B, through a small set of memory-mapped registers. Each side has its own single-cycle read/write port and its own interrupt line. There are four data indices. A word that one side writes into its transmit register n shows up in receive register n of the other side. Every index carries a handshake: the sender sees a transmit-empty flag and the receiver sees a receive-full flag. The sender polls transmit-empty before it reuses a transmit register. The receiver polls receive-full before it reads. Longer messages are sent by cycling through indices 0, 1, 2, 3, 0 and so on.

Alongside the data path, each side can ring a doorbell toward its peer. Setting a request bit in its own control register raises a pending flag in the peer's status register. The peer clears that flag by writing 1 to it, and the request bit then drops on its own. Each side's interrupt output is a registered OR, taken over all indices, of each flag combined with its matching enable bit.

Word offsets (byte address, bits [1:0] zero): transmit n at 0x00 + 4n, receive n at 0x10 + 4n, status at 0x20, control at 0x24.

Top module: `mu_dual_side`

## Requirements
- R1: After synchronous reset, each side's status reads 0x00F00000 (all transmit-empty set, nothing else), each control register reads 0, and both interrupt outputs are low.
- R2: A word written to transmit register n on one side is returned by receive register n on the other side. Read data appears on rdata in the cycle after the read strobe.
- R3: A write to transmit register n sets receive-full (status bit 24+(3-n)) on the peer and clears transmit-empty (status bit 20+(3-n)) on the writer. Both changes are visible from the next cycle.
- R4: Reading receive register n clears the reader's receive-full bit for n and sets the peer's transmit-empty bit for n. Reads of any other register leave every flag unchanged.
- R5: When the peer writes transmit register n in the same cycle that the local side reads receive register n, the read returns the older word. Receive-full stays set, and the newer word is kept for the next read.
- R6: Writing control with bit 16+(3-n) set sets the peer's pending bit at status bit 28+(3-n). The request bit reads back as 1 while that pending bit is set.
- R7: Writing 1 to a status pending bit clears it, and writing 0 leaves it unchanged. A clear that takes effect also drops the peer's request bit for that index.
- R8: Control bits 20+(3-n), 24+(3-n) and 28+(3-n) are the transmit, receive and doorbell interrupt enables for index n. Bits 16..31 read back as written, bits 0..15 read as zero, and writing 0 turns off every enable and request.
- R9: A side's interrupt output equals, one cycle after the state changes, the OR over n of (transmit-empty AND transmit enable), (receive-full AND receive enable) and (pending AND doorbell enable).
- R10: The four indices are independent. A five-word message sent through indices 0,1,2,3,0, with the sender waiting for transmit-empty on index 0 before reusing it, arrives in order.
- R11: Transmit registers and unmapped word offsets read as zero. Accesses whose byte address bits [1:0] are non-zero are ignored and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A registered read data |
| a_irq | output | 1 | Side A interrupt |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B registered read data |
| b_irq | output | 1 | Side B interrupt |

## Verification
Two pairs of functions can land in one cycle. The first pair is a sender's write to transmit register n and the receiver's read of receive register n. The second is a doorbell request from one side and the other side clearing the matching pending bit. The bench forces the first pair by putting both strobes in the same clock on the two ports. It then judges the result from the returned word, the flag still showing in the receiver's status, and the word returned by a second read. For the doorbell, the bench checks that a write of 0 to the pending bit leaves it set, and that a write of 1 clears it and withdraws the peer's request.

// File: rtl/mu_pkg.sv
package mu_pkg;
  localparam int REG_W    = 32;
  localparam int NUM_IDX  = 4;
  localparam int ADDR_W   = 6;
  // Bit field bases; index n sits at BASE + (NUM_IDX-1-n)
  localparam int GIR_BASE = 16;
  localparam int TXE_BASE = 20;
  localparam int RXF_BASE = 24;
  localparam int GIP_BASE = 28;
  localparam int TIE_BASE = 20;
  localparam int RIE_BASE = 24;
  localparam int GIE_BASE = 28;
endpackage

// File: rtl/mu_channel.sv
// One direction of one data index: a word register plus its full flag.
module mu_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  logic [W-1:0] data_q;
  logic         full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (wr_i) begin
      data_q <= wdata_i;
      full_q <= 1'b1;
    end else if (rd_i) begin
      full_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst) wr_i |=> full_q); // R3
  AST_WORD_KEPT: assert property (@(posedge clk) disable iff (rst) wr_i |=> data_q == $past(wdata_i)); // R2
  AST_READ_DRAINS: assert property (@(posedge clk) disable iff (rst) (rd_i && !wr_i) |=> !full_q); // R4
endmodule

// File: rtl/mu_side_ctrl.sv
// Per-side control register and doorbell pending flags.
module mu_side_ctrl
  import mu_pkg::*;
#(
  parameter int N = NUM_IDX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we_i,
  input  logic             stat_we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [N-1:0]     peer_req_set_i,
  input  logic [N-1:0]     peer_pend_clr_i,
  output logic [N-1:0]     req_set_o,
  output logic [N-1:0]     pend_clr_o,
  output logic [N-1:0]     req_o,
  output logic [N-1:0]     tie_o,
  output logic [N-1:0]     rie_o,
  output logic [N-1:0]     gie_o,
  output logic [N-1:0]     pend_o
);
  logic [N-1:0] req_q, tie_q, rie_q, gie_q, pend_q;

  for (genvar n = 0; n < N; n++) begin : g_idx
    localparam int OFS = N - 1 - n;

    assign req_set_o[n]  = ctrl_we_i && wdata_i[GIR_BASE + OFS];
    // A clear counts only when it really takes the flag down.
    assign pend_clr_o[n] = stat_we_i && wdata_i[GIP_BASE + OFS] && pend_q[n] && !peer_req_set_i[n];

    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[n] <= 1'b0;
        tie_q[n] <= 1'b0;
        rie_q[n] <= 1'b0;
        gie_q[n] <= 1'b0;
      end else if (ctrl_we_i) begin
        req_q[n] <= wdata_i[GIR_BASE + OFS];
        tie_q[n] <= wdata_i[TIE_BASE + OFS];
        rie_q[n] <= wdata_i[RIE_BASE + OFS];
        gie_q[n] <= wdata_i[GIE_BASE + OFS];
      end else if (peer_pend_clr_i[n]) begin
        req_q[n] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                 pend_q[n] <= 1'b0;
      else if (peer_req_set_i[n]) pend_q[n] <= 1'b1;
      else if (pend_clr_o[n])  pend_q[n] <= 1'b0;
    end

    AST_DOORBELL_SETS: assert property (@(posedge clk) disable iff (rst) peer_req_set_i[n] |=> pend_q[n]); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst) pend_clr_o[n] |=> !pend_q[n]); // R7
    AST_REQ_WITHDRAWN: assert property (@(posedge clk) disable iff (rst) (peer_pend_clr_i[n] && !ctrl_we_i) |=> !req_q[n]); // R7
  end

  assign req_o  = req_q;
  assign tie_o  = tie_q;
  assign rie_o  = rie_q;
  assign gie_o  = gie_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/mu_side_port.sv
// Address decode, registered read mux and registered interrupt for one side.
module mu_side_port
  import mu_pkg::*;
#(
  parameter int N  = NUM_IDX,
  parameter int AW = ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [N-1:0]             tx_empty_i,
  input  logic [N-1:0]             rx_full_i,
  input  logic [N-1:0]             pend_i,
  input  logic [N-1:0]             req_i,
  input  logic [N-1:0]             tie_i,
  input  logic [N-1:0]             rie_i,
  input  logic [N-1:0]             gie_i,
  input  logic [N-1:0][REG_W-1:0]  rx_data_i,
  output logic [N-1:0]             tx_we_o,
  output logic [N-1:0]             rx_re_o,
  output logic                     stat_we_o,
  output logic                     ctrl_we_o,
  output logic [REG_W-1:0]         rdata_o,
  output logic                     irq_o
);
  localparam int WIDX_W = AW - 2;
  localparam logic [WIDX_W-1:0] STAT_WORD = WIDX_W'(2 * N);
  localparam logic [WIDX_W-1:0] CTRL_WORD = WIDX_W'(2 * N + 1);

  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic [REG_W-1:0]  stat_word, ctrl_word, rd_next;
  logic              irq_next;

  assign widx    = addr_i[AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    stat_word = '0;
    ctrl_word = '0;
    for (int i = 0; i < N; i++) begin
      stat_word[TXE_BASE + N - 1 - i] = tx_empty_i[i];
      stat_word[RXF_BASE + N - 1 - i] = rx_full_i[i];
      stat_word[GIP_BASE + N - 1 - i] = pend_i[i];
      ctrl_word[GIR_BASE + N - 1 - i] = req_i[i];
      ctrl_word[TIE_BASE + N - 1 - i] = tie_i[i];
      ctrl_word[RIE_BASE + N - 1 - i] = rie_i[i];
      ctrl_word[GIE_BASE + N - 1 - i] = gie_i[i];
    end
  end

  always_comb begin
    tx_we_o   = '0;
    rx_re_o   = '0;
    rd_next   = '0;
    stat_we_o = wr_en_i && aligned && (widx == STAT_WORD);
    ctrl_we_o = wr_en_i && aligned && (widx == CTRL_WORD);
    for (int i = 0; i < N; i++) begin
      tx_we_o[i] = wr_en_i && aligned && (widx == WIDX_W'(i));
      rx_re_o[i] = rd_en_i && aligned && (widx == WIDX_W'(N + i));
      if (rx_re_o[i]) rd_next = rx_data_i[i];
    end
    if (aligned && widx == STAT_WORD) rd_next = stat_word;
    if (aligned && widx == CTRL_WORD) rd_next = ctrl_word;
  end

  assign irq_next = |((tx_empty_i & tie_i) | (rx_full_i & rie_i) | (pend_i & gie_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_o <= rd_next;
      irq_o <= irq_next;
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst) ((tie_i | rie_i | gie_i) == '0) |=> !irq_o); // R9
endmodule

// File: rtl/mu_dual_side.sv
module mu_dual_side
  import mu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              a_wr_en,
  input  logic              a_rd_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [REG_W-1:0]  a_wdata,
  output logic [REG_W-1:0]  a_rdata,
  output logic              a_irq,
  input  logic              b_wr_en,
  input  logic              b_rd_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [REG_W-1:0]  b_wdata,
  output logic [REG_W-1:0]  b_rdata,
  output logic              b_irq
);
  localparam int N = NUM_IDX;

  logic [N-1:0][REG_W-1:0] data_ab, data_ba;
  logic [N-1:0] full_ab, full_ba;
  logic [N-1:0] a_tx_we, a_rx_re, b_tx_we, b_rx_re;
  logic         a_stat_we, a_ctrl_we, b_stat_we, b_ctrl_we;
  logic [N-1:0] a_req_set, a_pend_clr, b_req_set, b_pend_clr;
  logic [N-1:0] a_req, a_tie, a_rie, a_gie, a_pend;
  logic [N-1:0] b_req, b_tie, b_rie, b_gie, b_pend;

  for (genvar n = 0; n < N; n++) begin : g_lane
    mu_channel #(.W(REG_W)) u_ab (
      .clk(clk), .rst(rst), .wr_i(a_tx_we[n]), .wdata_i(a_wdata),
      .rd_i(b_rx_re[n]), .data_o(data_ab[n]), .full_o(full_ab[n]));
    mu_channel #(.W(REG_W)) u_ba (
      .clk(clk), .rst(rst), .wr_i(b_tx_we[n]), .wdata_i(b_wdata),
      .rd_i(a_rx_re[n]), .data_o(data_ba[n]), .full_o(full_ba[n]));
  end

  mu_side_ctrl #(.N(N)) u_ctrl_a (
    .clk(clk), .rst(rst), .ctrl_we_i(a_ctrl_we), .stat_we_i(a_stat_we), .wdata_i(a_wdata),
    .peer_req_set_i(b_req_set), .peer_pend_clr_i(b_pend_clr),
    .req_set_o(a_req_set), .pend_clr_o(a_pend_clr), .req_o(a_req),
    .tie_o(a_tie), .rie_o(a_rie), .gie_o(a_gie), .pend_o(a_pend));

  mu_side_ctrl #(.N(N)) u_ctrl_b (
    .clk(clk), .rst(rst), .ctrl_we_i(b_ctrl_we), .stat_we_i(b_stat_we), .wdata_i(b_wdata),
    .peer_req_set_i(a_req_set), .peer_pend_clr_i(a_pend_clr),
    .req_set_o(b_req_set), .pend_clr_o(b_pend_clr), .req_o(b_req),
    .tie_o(b_tie), .rie_o(b_rie), .gie_o(b_gie), .pend_o(b_pend));

  mu_side_port #(.N(N), .AW(ADDR_W)) u_port_a (
    .clk(clk), .rst(rst), .wr_en_i(a_wr_en), .rd_en_i(a_rd_en), .addr_i(a_addr),
    .tx_empty_i(~full_ab), .rx_full_i(full_ba), .pend_i(a_pend), .req_i(a_req),
    .tie_i(a_tie), .rie_i(a_rie), .gie_i(a_gie), .rx_data_i(data_ba),
    .tx_we_o(a_tx_we), .rx_re_o(a_rx_re), .stat_we_o(a_stat_we), .ctrl_we_o(a_ctrl_we),
    .rdata_o(a_rdata), .irq_o(a_irq));

  mu_side_port #(.N(N), .AW(ADDR_W)) u_port_b (
    .clk(clk), .rst(rst), .wr_en_i(b_wr_en), .rd_en_i(b_rd_en), .addr_i(b_addr),
    .tx_empty_i(~full_ba), .rx_full_i(full_ab), .pend_i(b_pend), .req_i(b_req),
    .tie_i(b_tie), .rie_i(b_rie), .gie_i(b_gie), .rx_data_i(data_ab),
    .tx_we_o(b_tx_we), .rx_re_o(b_rx_re), .stat_we_o(b_stat_we), .ctrl_we_o(b_ctrl_we),
    .rdata_o(b_rdata), .irq_o(b_irq));

  AST_SAME_CYCLE_KEEPS: assert property (@(posedge clk) disable iff (rst) (a_tx_we[0] && b_rx_re[0]) |=> full_ab[0]); // R5
endmodule

// File: tb/mu_dual_side_bench.sv
module mu_dual_side_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] STAT = 6'h20;
  localparam logic [5:0] CTRL = 6'h24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [5:0] a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic a_irq, b_irq;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic a_iss = 0, b_iss = 0;
  logic [31:0] qa[$], qb[$];
  string ta[$], tb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mu_dual_side u_mu_dual_side (
    .clk(clk), .rst(rst),
    .a_wr_en(a_wr), .a_rd_en(a_rd), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_wr_en(b_wr), .b_rd_en(b_rd), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data from the scoreboard queues.
  always @(posedge clk) begin
    a_iss <= a_rd;
    b_iss <= b_rd;
  end
  always @(negedge clk) begin
    if (a_iss) begin
      if (qa.size() == 0) check("scoreboard A empty", 32'h1, 32'h0);
      else check(ta.pop_front(), a_rdata, qa.pop_front());
    end
    if (b_iss) begin
      if (qb.size() == 0) check("scoreboard B empty", 32'h1, 32'h0);
      else check(tb.pop_front(), b_rdata, qb.pop_front());
    end
  end

  task automatic wr(input bit s, input logic [5:0] ad, input logic [31:0] d);
    if (!s) begin a_wr = 1; a_addr = ad; a_wdata = d; end
    else    begin b_wr = 1; b_addr = ad; b_wdata = d; end
    @(negedge clk);
    a_wr = 0; b_wr = 0;
  endtask

  task automatic rd(input bit s, input logic [5:0] ad, input logic [31:0] exp, input string tag);
    if (!s) begin a_rd = 1; a_addr = ad; qa.push_back(exp); ta.push_back(tag); end
    else    begin b_rd = 1; b_addr = ad; qb.push_back(exp); tb.push_back(tag); end
    @(negedge clk);
    a_rd = 0; b_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    rd(0, STAT, 32'h00F00000, "R1 A status after reset");
    rd(1, STAT, 32'h00F00000, "R1 B status after reset");
    rd(0, CTRL, 32'h0, "R1 A control after reset");
    rd(1, CTRL, 32'h0, "R1 B control after reset");
    check("R1 A irq after reset", {31'd0, a_irq}, 32'd0);
    check("R1 B irq after reset", {31'd0, b_irq}, 32'd0);
    // R3 write sets peer full, clears own empty
    wr(0, 6'h04, 32'hDEADBEEF);
    rd(1, STAT, 32'h04F00000, "R3 B rx-full index1");
    rd(0, STAT, 32'h00B00000, "R3 A tx-empty index1 cleared");
    // R2 data crosses
    rd(1, 6'h14, 32'hDEADBEEF, "R2 B reads index1");
    // R4 read side effects
    rd(1, STAT, 32'h00F00000, "R4 B rx-full cleared");
    rd(0, STAT, 32'h00F00000, "R4 A tx-empty restored");
    // R11 decode; R4 no side effects from other reads
    wr(0, 6'h08, 32'hA5A5A5A5);
    rd(0, 6'h08, 32'h0, "R11 transmit register reads zero");
    rd(0, 6'h3C, 32'h0, "R11 unmapped reads zero");
    rd(1, 6'h19, 32'h0, "R11 misaligned read zero");
    rd(0, STAT, 32'h00D00000, "R4 other reads leave flags");
    rd(1, STAT, 32'h02F00000, "R4 B full index2 untouched");
    rd(1, 6'h18, 32'hA5A5A5A5, "R2 B reads index2");
    wr(0, 6'h21, 32'hFFFFFFFF);
    rd(0, 6'h24, 32'h0, "R11 misaligned write ignored");
    // R5 coincident write and read on index 2
    wr(0, 6'h08, 32'h11111111);
    a_wr = 1; a_addr = 6'h08; a_wdata = 32'h22222222;
    b_rd = 1; b_addr = 6'h18; qb.push_back(32'h11111111); tb.push_back("R5 coincident read old word");
    @(negedge clk);
    a_wr = 0; b_rd = 0;
    rd(1, STAT, 32'h02F00000, "R5 full kept after coincident");
    rd(1, 6'h18, 32'h22222222, "R5 newer word retained");
    rd(1, STAT, 32'h00F00000, "R5 drained");
    // R10 five-word message B -> A
    for (int i = 0; i < 4; i++) wr(1, 6'(4*i), 32'hC0DE0000 + 32'(i));
    rd(0, STAT, 32'h0FF00000, "R10 A all rx-full");
    rd(1, STAT, 32'h00000000, "R10 B no tx-empty");
    rd(0, 6'h10, 32'hC0DE0000, "R10 word0");
    rd(1, STAT, 32'h00800000, "R10 B index0 free again");
    wr(1, 6'h00, 32'hC0DE0004);
    rd(0, 6'h14, 32'hC0DE0001, "R10 word1");
    rd(0, 6'h18, 32'hC0DE0002, "R10 word2");
    rd(0, 6'h1C, 32'hC0DE0003, "R10 word3");
    rd(0, 6'h10, 32'hC0DE0004, "R10 word4");
    rd(0, STAT, 32'h00F00000, "R10 A drained");
    // R8 enables readback and clear
    wr(0, CTRL, 32'hFFFFFFFF);
    rd(0, CTRL, 32'hFFFF0000, "R8 control readback");
    rd(1, STAT, 32'hF0F00000, "R6 all pending on B");
    check("R9 A irq from tx-empty", {31'd0, a_irq}, 32'd1);
    wr(0, CTRL, 32'h0);
    rd(0, CTRL, 32'h0, "R8 control cleared");
    idle(1);
    check("R9 A irq off with enables off", {31'd0, a_irq}, 32'd0);
    wr(1, STAT, 32'hF0000000);
    rd(1, STAT, 32'h00F00000, "R7 B pending cleared");
    // R6/R7 doorbell on index1
    wr(0, CTRL, 32'h00040000);
    rd(0, CTRL, 32'h00040000, "R6 request reads back");
    rd(1, STAT, 32'h40F00000, "R6 B pending index1");
    wr(1, STAT, 32'h00000000);
    rd(1, STAT, 32'h40F00000, "R7 write zero no effect");
    rd(0, CTRL, 32'h00040000, "R7 request held");
    wr(1, STAT, 32'h40000000);
    rd(1, STAT, 32'h00F00000, "R7 pending cleared");
    rd(0, CTRL, 32'h0, "R7 request withdrawn");
    // R9 receive interrupt
    wr(1, CTRL, 32'h01000000);
    idle(1);
    check("R9 B irq idle", {31'd0, b_irq}, 32'd0);
    wr(0, 6'h0C, 32'h00000033);
    idle(1);
    check("R9 B irq on rx-full", {31'd0, b_irq}, 32'd1);
    check("R9 A irq stays low", {31'd0, a_irq}, 32'd0);
    rd(1, 6'h1C, 32'h00000033, "R2 B reads index3");
    idle(1);
    check("R9 B irq after drain", {31'd0, b_irq}, 32'd0);
    // R9 doorbell interrupt
    wr(1, CTRL, 32'h10000000);
    wr(0, CTRL, 32'h00010000);
    idle(1);
    check("R9 B irq on pending", {31'd0, b_irq}, 32'd1);
    wr(1, STAT, 32'h10000000);
    idle(1);
    check("R9 B irq pending cleared", {31'd0, b_irq}, 32'd0);
    rd(0, CTRL, 32'h0, "R7 index3 request withdrawn");
    idle(2);
    finish_run();
  end
endmodule